// File: doc/BRIEF.md
# Dual-Channel Simultaneous-Sampling ADC Reader

This block is the host side of a link to a dual 12-bit converter that samples two channels at the same instant and returns them over a serial port. The two channels share one active-low select line and one serial clock. Results return either on two data lines, one per channel, or back to back on a single line. A conversion starts when `start_i` pulses or when an internal sample-rate timer expires. The reader then lowers select while the serial clock is idle high and toggles the clock at a half period set in system clocks. It samples the data line or lines and drops the four leading zero bits of each 16-clock channel slot. It presents both results as sign-extended 16-bit values with a one-cycle valid strobe.

Each frame is one sample, and select is raised again afterwards, so repeated sampling is a burst of separate frames. A short-cycle count K ends the frame once K result bits of the last channel have been taken. This trades resolution for a shorter frame. Mode, capture edge, divider and K are sampled when select falls and hold for the whole frame.

Top module: `dual_adc_reader`

## Requirements
- R1: After reset `cs_no` and `sclk_o` are high, `busy_o` and `valid_o` are low, and both results are zero.
- R2: With `cfg_single_i`=0, each 16-clock slot carries 4 zero bits and then 12 data bits, MSB first. Channel A is read from `sdata_a_i` and channel B from `sdata_b_i`. Each result is the 12-bit two's complement word with bit 11 copied into bits 15:12.
- R3: With `cfg_single_i`=1 the frame spans two slots on `sdata_a_i`, with channel A first and channel B second, and `sdata_b_i` has no effect on either result.
- R4: The converter changes data on serial clock falling edges. With `cfg_fall_cap_i`=0 each bit is taken at the following rising edge. With `cfg_fall_cap_i`=1 it is taken at the following falling edge, which adds one falling edge per frame. Both settings yield the same results.
- R5: `cfg_bits_i`=K (1..12; 0 or above 12 acts as 12) ends the frame after 4+K captured bits in dual mode, or 16+4+K in single mode. The number of falling edges while select is low equals that count, plus one with falling-edge capture. Each result keeps its K most significant bits and has the lower bits cleared, and in single mode channel A is cut to K bits as well.
- R6: `cs_no` falls only while `sclk_o` is high. The first falling edge follows `cfg_div_i` system clocks later (0 acts as 1), and each half period of `sclk_o` lasts `cfg_div_i` clocks. At frame end `cs_no` and `sclk_o` are both high.
- R7: `busy_o` rises with the falling edge of `cs_no` and drops in the cycle that `valid_o` pulses for one cycle. The two are never high together. A start request that arrives while busy starts no frame.
- R8: A nonzero `cfg_rate_i`=P starts a frame every P system clocks, and 0 disables the timer. A tick that comes while busy is dropped, so the next frame starts at the following tick.
- R9: A change to any configuration input while a frame runs does not affect that frame's timing or results.
- R10: The result outputs change only in a cycle where `valid_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request one frame |
| cfg_div_i | input | DIV_W | Serial clock half period in system clocks |
| cfg_rate_i | input | RATE_W | Sample timer period in system clocks, 0 off |
| cfg_single_i | input | 1 | 1: both channels on line A |
| cfg_fall_cap_i | input | 1 | 1: capture on the next falling edge |
| cfg_bits_i | input | BITS_W | Short-cycle result bit count K |
| cs_no | output | 1 | Converter select, active low |
| sclk_o | output | 1 | Serial clock, idle high |
| sdata_a_i | input | 1 | Serial data line A |
| sdata_b_i | input | 1 | Serial data line B |
| result_a_o | output | OUT_W | Channel A result, sign-extended |
| result_b_o | output | OUT_W | Channel B result, sign-extended |
| valid_o | output | 1 | One-cycle pulse with new results |
| busy_o | output | 1 | Frame in progress |

## Verification
The reader runs against a bench model of the converter's serial output. Full-scale words 7FFh and 800h show whether the sign is extended correctly. Random words combined with random K, divider, mode and capture edge show bit order, slot alignment and truncation. In single-line mode line B toggles on every edge, so any use of it corrupts a result. Start pulses during a frame, configuration changes during a frame, and timer periods both longer and shorter than a frame separate correct ignoring and latching from leaks and from ticks that are queued.

// File: rtl/dar_pkg.sv
package dar_pkg;
  localparam int NUM_CH = 2;
  typedef enum logic [0:0] {ST_IDLE, ST_RUN} dar_state_e;
endpackage

// File: rtl/dar_rate_timer.sv
module dar_rate_timer #(
  parameter int RATE_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [RATE_W-1:0] period_i,
  output logic              tick_o
);
  logic [RATE_W-1:0] cnt_q;

  assign tick_o = (period_i != '0) && (cnt_q == period_i - 1'b1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                       cnt_q <= '0;
    else if (period_i == '0)           cnt_q <= '0;
    else if (cnt_q >= period_i - 1'b1) cnt_q <= '0;
    else                               cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/dar_half_timer.sv
module dar_half_timer #(
  parameter int DIV_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [DIV_W-1:0] half_i,
  output logic             expire_o
);
  logic [DIV_W-1:0] cnt_q;

  assign expire_o = run_i && (cnt_q == half_i - 1'b1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 cnt_q <= '0;
    else if (!run_i || expire_o) cnt_q <= '0;
    else                         cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/dar_chan_capture.sv
module dar_chan_capture #(
  parameter int RES_W  = 12,
  parameter int BITS_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clear_i,
  input  logic              shift_i,
  input  logic              bit_i,
  input  logic [BITS_W-1:0] keep_i,
  output logic [RES_W-1:0]  word_o
);
  localparam logic [BITS_W-1:0] RES_B = BITS_W'(RES_W);

  logic [RES_W-1:0]  sh_q, aligned, mask;
  logic [BITS_W-1:0] nb_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q <= '0;
      nb_q <= '0;
    end else if (clear_i) begin
      sh_q <= '0;
      nb_q <= '0;
    end else if (shift_i) begin
      sh_q <= {sh_q[RES_W-2:0], bit_i};
      if (nb_q != RES_B) nb_q <= nb_q + 1'b1;
    end
  end

  // left-align the bits taken, then keep only the K MSBs
  always_comb begin
    aligned = sh_q << (RES_B - nb_q);
    mask    = ~({RES_W{1'b1}} >> keep_i);
    word_o  = aligned & mask;
  end
endmodule

// File: rtl/dual_adc_reader.sv
module dual_adc_reader
  import dar_pkg::*;
#(
  parameter int DIV_W  = 8,
  parameter int RATE_W = 16,
  parameter int RES_W  = 12,
  parameter int LEAD_N = 4,
  parameter int OUT_W  = 16,
  localparam int BITS_W = $clog2(RES_W + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [DIV_W-1:0]  cfg_div_i,
  input  logic [RATE_W-1:0] cfg_rate_i,
  input  logic              cfg_single_i,
  input  logic              cfg_fall_cap_i,
  input  logic [BITS_W-1:0] cfg_bits_i,
  output logic              cs_no,
  output logic              sclk_o,
  input  logic              sdata_a_i,
  input  logic              sdata_b_i,
  output logic [OUT_W-1:0]  result_a_o,
  output logic [OUT_W-1:0]  result_b_o,
  output logic              valid_o,
  output logic              busy_o
);
  localparam int SLOT  = LEAD_N + RES_W;
  localparam int IDX_W = $clog2(2 * SLOT + 2);
  localparam logic [IDX_W-1:0]  LEAD_I  = IDX_W'(LEAD_N);
  localparam logic [IDX_W-1:0]  SLOT_I  = IDX_W'(SLOT);
  localparam logic [IDX_W-1:0]  BLEAD_I = IDX_W'(SLOT + LEAD_N);
  localparam logic [IDX_W-1:0]  SLOT2_I = IDX_W'(2 * SLOT);
  localparam logic [BITS_W-1:0] RES_B   = BITS_W'(RES_W);

  dar_state_e state_q;
  logic cs_q, sclk_q, first_q, fin_q, valid_q, single_q, fall_q;
  logic [DIV_W-1:0]  div_q, div_eff;
  logic [BITS_W-1:0] bits_q, bits_eff;
  logic [IDX_W-1:0]  idx_q, idx_n, total_q, total_eff;
  logic [OUT_W-1:0]  res_a_q, res_b_q;
  logic tick, expire, trig, cap, step, in_a, in_b;
  logic [NUM_CH-1:0] shift_v, bit_v;
  logic [RES_W-1:0]  word_v [NUM_CH];

  dar_rate_timer #(.RATE_W(RATE_W)) u_rate (
    .clk_i(clk_i), .rst_ni(rst_ni), .period_i(cfg_rate_i), .tick_o(tick)
  );

  dar_half_timer #(.DIV_W(DIV_W)) u_half (
    .clk_i(clk_i), .rst_ni(rst_ni), .run_i(state_q == ST_RUN),
    .half_i(div_q), .expire_o(expire)
  );

  always_comb begin
    bits_eff  = (cfg_bits_i == '0 || cfg_bits_i > RES_B) ? RES_B : cfg_bits_i;
    div_eff   = (cfg_div_i == '0) ? DIV_W'(1) : cfg_div_i;
    total_eff = (cfg_single_i ? BLEAD_I : LEAD_I) + IDX_W'(bits_eff);
    trig      = (start_i | tick) && (state_q == ST_IDLE);
    // rising capture: edge after each fall; falling capture: every fall but the first
    cap       = fall_q ? (sclk_q && first_q) : !sclk_q;
    step      = (state_q == ST_RUN) && expire && !fin_q;
    idx_n     = idx_q + 1'b1;
    in_a      = (idx_n > LEAD_I) && (idx_n <= SLOT_I);
    in_b      = single_q ? ((idx_n > BLEAD_I) && (idx_n <= SLOT2_I)) : in_a;
    shift_v   = {step && cap && in_b, step && cap && in_a};
    bit_v     = {single_q ? sdata_a_i : sdata_b_i, sdata_a_i};
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    dar_chan_capture #(.RES_W(RES_W), .BITS_W(BITS_W)) u_cap (
      .clk_i(clk_i), .rst_ni(rst_ni), .clear_i(trig),
      .shift_i(shift_v[c]), .bit_i(bit_v[c]), .keep_i(bits_q),
      .word_o(word_v[c])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      cs_q     <= 1'b1;
      sclk_q   <= 1'b1;
      first_q  <= 1'b0;
      fin_q    <= 1'b0;
      valid_q  <= 1'b0;
      single_q <= 1'b0;
      fall_q   <= 1'b0;
      div_q    <= DIV_W'(1);
      bits_q   <= RES_B;
      idx_q    <= '0;
      total_q  <= '0;
      res_a_q  <= '0;
      res_b_q  <= '0;
    end else begin
      valid_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (trig) begin
            div_q    <= div_eff;
            bits_q   <= bits_eff;
            single_q <= cfg_single_i;
            fall_q   <= cfg_fall_cap_i;
            total_q  <= total_eff;
            cs_q     <= 1'b0;
            idx_q    <= '0;
            first_q  <= 1'b0;
            fin_q    <= 1'b0;
            state_q  <= ST_RUN;
          end
        end
        ST_RUN: begin
          if (expire) begin
            if (fin_q) begin
              cs_q    <= 1'b1;
              sclk_q  <= 1'b1;
              valid_q <= 1'b1;
              state_q <= ST_IDLE;
              res_a_q <= {{(OUT_W-RES_W){word_v[0][RES_W-1]}}, word_v[0]};
              res_b_q <= {{(OUT_W-RES_W){word_v[1][RES_W-1]}}, word_v[1]};
            end else begin
              sclk_q <= !sclk_q;
              if (sclk_q) first_q <= 1'b1;
              if (cap) begin
                idx_q <= idx_n;
                if (idx_n == total_q) fin_q <= 1'b1;
              end
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign cs_no      = cs_q;
  assign sclk_o     = sclk_q;
  assign valid_o    = valid_q;
  assign busy_o     = (state_q == ST_RUN);
  assign result_a_o = res_a_q;
  assign result_b_o = res_b_q;
endmodule

// File: rtl/dar_checker.sv
module dar_checker #(
  parameter int OUT_W = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             cs_no,
  input logic             sclk_o,
  input logic             busy_o,
  input logic             valid_o,
  input logic [OUT_W-1:0] result_a_o,
  input logic [OUT_W-1:0] result_b_o
);
  assert_cs_fall_sclk_high_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(cs_no) |-> sclk_o);

  assert_sclk_idle_when_deselected_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_no |-> sclk_o);

  assert_no_fall_with_cs_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(cs_no) |-> !$fell(sclk_o));

  assert_busy_at_cs_fall_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(cs_no) |-> busy_o);

  assert_busy_valid_excl_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(busy_o && valid_o));

  assert_valid_one_cycle_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o);

  assert_valid_with_cs_rise_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> $rose(cs_no));

  assert_result_a_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(result_a_o) |-> valid_o);

  assert_result_b_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(result_b_o) |-> valid_o);
endmodule

bind dual_adc_reader dar_checker #(.OUT_W(OUT_W)) u_dar_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .cs_no(cs_no), .sclk_o(sclk_o),
  .busy_o(busy_o), .valid_o(valid_o),
  .result_a_o(result_a_o), .result_b_o(result_b_o)
);

// File: tb/dual_adc_reader_tb_top.sv
`timescale 1ns/1ps
module dual_adc_reader_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [7:0]  cfg_div = 8'd2;
  logic [15:0] cfg_rate = '0;
  logic cfg_single = 1'b0, cfg_fall = 1'b0;
  logic [3:0]  cfg_bits = 4'd12;
  logic cs_no, sclk_o, sdata_a, sdata_b, valid_o, busy_o;
  logic [15:0] result_a_o, result_b_o;

  int n_chk = 0, n_err = 0;
  int n_frames = 0, fall_cnt = 0, ptr = 0;
  time t_cs = 0, t_f1 = 0, t_f2 = 0;
  logic sclk_at_cs = 1'b0;
  logic [11:0] m_va = '0, m_vb = '0;
  logic m_single = 1'b0;

  always #2.5 clk = ~clk;

  dual_adc_reader dut_i (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start),
    .cfg_div_i(cfg_div), .cfg_rate_i(cfg_rate), .cfg_single_i(cfg_single),
    .cfg_fall_cap_i(cfg_fall), .cfg_bits_i(cfg_bits),
    .cs_no(cs_no), .sclk_o(sclk_o), .sdata_a_i(sdata_a), .sdata_b_i(sdata_b),
    .result_a_o(result_a_o), .result_b_o(result_b_o),
    .valid_o(valid_o), .busy_o(busy_o)
  );

  // converter output model: data changes after each falling edge
  function automatic logic line_bit(logic [31:0] s, int k);
    if (k < 1 || k > 32) return 1'b0;
    return s[32-k];
  endfunction

  assign sdata_a = cs_no ? 1'b0 :
    line_bit(m_single ? {4'h0, m_va, 4'h0, m_vb} : {4'h0, m_va, 16'h0}, ptr);
  assign sdata_b = cs_no ? 1'b0 :
    (m_single ? ptr[0] : line_bit({4'h0, m_vb, 16'h0}, ptr));

  always @(negedge cs_no) begin
    ptr = 0; n_frames++; t_cs = $time; sclk_at_cs = sclk_o; fall_cnt = 0;
  end

  always @(negedge sclk_o) if (!cs_no) begin
    ptr++;
    if (fall_cnt == 0) t_f1 = $time;
    else if (fall_cnt == 1) t_f2 = $time;
    fall_cnt++;
  end

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] exp_res(logic [11:0] v, int k);
    logic [11:0] w;
    w = v & (12'hFFF << (12 - k));
    return {{4{w[11]}}, w};
  endfunction

  task automatic run_frame(input logic [11:0] a, input logic [11:0] b, input bit sgl,
                           input bit fcap, input int bits, input int div,
                           input bit poke, input bit twid);
    int k, de, exp_falls, nf0;
    bit got;
    string tg;
    k  = (bits == 0 || bits > 12) ? 12 : bits;
    de = (div == 0) ? 1 : div;
    exp_falls = (sgl ? 20 : 4) + k + (fcap ? 1 : 0);
    tg = $sformatf("%s%s%s%s", sgl ? "R3" : "R2", fcap ? " R4" : "",
                   (k < 12) ? " R5" : "", twid ? " R9" : "");
    @(negedge clk);
    m_va = a; m_vb = b; m_single = sgl;
    cfg_single = sgl; cfg_fall = fcap; cfg_bits = 4'(bits); cfg_div = 8'(div);
    nf0 = n_frames;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check("R7 busy after start", 32'(busy_o), 1);
    check("R6 cs low after start", 32'(cs_no), 0);
    got = 1'b0;
    for (int i = 0; i < 3000 && !got; i++) begin
      if (i == 3 && twid) begin
        cfg_bits = ~cfg_bits; cfg_single = !sgl; cfg_fall = !fcap; cfg_div = cfg_div + 8'd3;
      end
      if (i == 8 && poke) start = 1'b1;
      if (i == 9) start = 1'b0;
      @(negedge clk);
      if (valid_o) got = 1'b1;
    end
    start = 1'b0;
    check("R7 frame completed", 32'(got), 1);
    check({tg, " result_a"}, 32'(result_a_o), 32'(exp_res(a, k)));
    check({tg, " result_b"}, 32'(result_b_o), 32'(exp_res(b, k)));
    check("R7 busy low at valid", 32'(busy_o), 0);
    check("R6 cs high at end", 32'(cs_no), 1);
    check("R6 sclk high at end", 32'(sclk_o), 1);
    check("R5 falling edge count", 32'(fall_cnt), 32'(exp_falls));
    check("R6 sclk high at cs fall", 32'(sclk_at_cs), 1);
    check("R6 first fall delay", 32'((t_f1 - t_cs) / 5), 32'(de));
    check("R6 sclk period", 32'((t_f2 - t_f1) / 5), 32'(2 * de));
    cfg_single = sgl; cfg_fall = fcap; cfg_bits = 4'(bits); cfg_div = 8'(div);
    repeat (3) @(negedge clk);
    check("R10 result_a held", 32'(result_a_o), 32'(exp_res(a, k)));
    if (poke) begin
      repeat (20) @(negedge clk);
      check("R7 start while busy ignored", 32'(n_frames), 32'(nf0 + 1));
      check("R7 idle after ignored start", 32'(cs_no), 1);
    end
  endtask

  task automatic wait_frames(input int n);
    int target = n_frames + n;
    for (int i = 0; i < 5000 && n_frames < target; i++) @(negedge clk);
  endtask

  initial begin
    #750000;
    n_err++;
    $display("FAIL watchdog R7 actual=hung expected=finished");
    $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    time t1, t2, t3;
    int nf0;
    void'($urandom(32'h5EED_1234));
    repeat (5) @(negedge clk);
    check("R1 cs_no reset", 32'(cs_no), 1);
    check("R1 sclk reset", 32'(sclk_o), 1);
    check("R1 busy reset", 32'(busy_o), 0);
    check("R1 valid reset", 32'(valid_o), 0);
    check("R1 result_a reset", 32'(result_a_o), 0);
    check("R1 result_b reset", 32'(result_b_o), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // directed corners
    run_frame(12'h7FF, 12'h800, 1'b0, 1'b0, 12, 2, 1'b0, 1'b0);
    run_frame(12'h800, 12'h7FF, 1'b0, 1'b1, 12, 1, 1'b0, 1'b0);
    run_frame(12'hA5C, 12'h3C6, 1'b1, 1'b0, 12, 3, 1'b0, 1'b0);
    run_frame(12'hFFF, 12'h001, 1'b1, 1'b1, 12, 0, 1'b0, 1'b0);
    run_frame(12'hFFF, 12'h7FF, 1'b0, 1'b0, 1, 2, 1'b0, 1'b0);
    run_frame(12'h9AB, 12'h5CD, 1'b1, 1'b1, 5, 2, 1'b0, 1'b0);
    run_frame(12'h123, 12'hF00, 1'b0, 1'b0, 0, 2, 1'b0, 1'b0);
    run_frame(12'h456, 12'hABC, 1'b0, 1'b1, 15, 1, 1'b1, 1'b0);
    run_frame(12'hC3A, 12'h2B7, 1'b0, 1'b0, 7, 2, 1'b0, 1'b1);
    run_frame(12'h3E1, 12'hD42, 1'b1, 1'b0, 9, 2, 1'b1, 1'b1);

    // random frames
    for (int n = 0; n < 40; n++) begin
      run_frame(12'($urandom), 12'($urandom), 1'($urandom), 1'($urandom),
                int'($urandom_range(0, 15)), int'($urandom_range(1, 3)),
                ($urandom_range(0, 3) == 0), ($urandom_range(0, 3) == 0));
    end

    // sample-rate timer: R8
    @(negedge clk);
    m_va = 12'h6B1; m_vb = 12'h94E; m_single = 1'b0;
    cfg_single = 1'b0; cfg_fall = 1'b0; cfg_bits = 4'd12; cfg_div = 8'd2;
    cfg_rate = 16'd200;
    wait_frames(1); t1 = t_cs;
    wait_frames(1); t2 = t_cs;
    wait_frames(1); t3 = t_cs;
    check("R8 tick interval 1", 32'((t2 - t1) / 5), 200);
    check("R8 tick interval 2", 32'((t3 - t2) / 5), 200);
    while (!valid_o) @(negedge clk);
    check("R8 timed result_a", 32'(result_a_o), 32'(exp_res(12'h6B1, 12)));
    check("R8 timed result_b", 32'(result_b_o), 32'(exp_res(12'h94E, 12)));
    // 40-cycle period, 66-cycle frame: every other tick dropped
    cfg_rate = 16'd40;
    wait_frames(1); t1 = t_cs;
    wait_frames(1); t2 = t_cs;
    check("R8 busy tick dropped", 32'((t2 - t1) / 5), 80);
    while (!valid_o) @(negedge clk);
    cfg_rate = 16'd0;
    @(negedge clk);
    nf0 = n_frames;
    repeat (400) @(negedge clk);
    check("R8 timer disabled", 32'(n_frames), 32'(nf0));

    $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule